// File: doc/BRIEF.md
# MAC Interrupt Status, Gating and Receive Coalescing Unit

This unit merges the event sources of an Ethernet MAC into one level-sensitive interrupt line. The MAC logic sends one-cycle pulses for a received frame, a transmitted packet and a drained transmit FIFO. Each pulse latches a bit in a raw status word that software clears by writing ones. An enable word then gates the raw bits in two stages. A per-event mask comes first. Above it sit a port gate and a global gate, and both must be open before the line can rise.

Received frames also feed a coalescer. The coalescer raises a multi-frame receive event once a programmed number of frames has arrived. It also raises that event when a countdown timer runs out while received frames are still waiting to be consumed. The single-frame receive bit is backed by a count of unconsumed frames. It stays set until software has acknowledged every frame, one clear-write per frame.

The coalescer is a state machine with three states. CS_IDLE means no frame has arrived since the last event. CS_COLLECT means frames are being counted and the timer runs. CS_FIRE lasts one cycle and sets the multi-frame bit. The transitions are:
- CS_IDLE goes to CS_COLLECT on a frame. It goes straight to CS_FIRE when the threshold is 0 or 1.
- CS_COLLECT goes to CS_FIRE when a frame brings the count up to the threshold.
- CS_COLLECT goes to CS_FIRE when the timer expires with frames pending.
- CS_COLLECT goes to CS_IDLE when the timer expires and nothing is pending.
- CS_FIRE goes back to CS_IDLE, or to CS_COLLECT or CS_FIRE if a new frame arrives in that same cycle.

The register interface is a simple word-addressed write strobe with a combinational read. Word 0 is the raw status. Word 1 is the enable register. Word 2 is the coalescing setup. Word 3 reads as zero.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After reset the raw status reads 0, the enable register reads 0, the coalescing word reads 0x0800_0074 (threshold 8, timer 0x74) and `irq` is low.
- R2: A pulse on `ev_tx_done` sets raw bit 1 and a pulse on `ev_tx_empty` sets raw bit 6. These bits stay set until cleared, and writing 0 to them leaves them unchanged.
- R3: Writing 1 to a raw bit clears it. When an event pulse and a clear-write hit the same bit in the same cycle, the bit remains set.
- R4: Raw bit 0 reads 1 while any received frame is still unconsumed. Each write of 1 to bit 0 consumes exactly one frame.
- R5: In the enable register only bits 7:0 (per-event enables), bit 18 (port gate) and bit 19 (global gate) are stored; all other bits read 0. Raw bits 5:2 and register word 3 always read 0.
- R6: `irq` is high exactly when some raw bit and its matching enable bit are both set and both gate bits 18 and 19 are set.
- R7: With threshold N (coalescing bits 31:24), raw bit 7 is set after the N-th received frame counted since the last multi-frame event and not earlier. The frame count then starts again from zero.
- R8: The timer (coalescing bits 15:0) loads on the first frame after an event. It counts down once every TICK_DIV cycles. When it expires with frames still pending, raw bit 7 is set (load value T gives (T+1)*TICK_DIV cycles).
- R9: If the timer expires after all received frames have been consumed, raw bit 7 stays clear and the coalescer returns to idle.
- R10: A threshold of 0 or 1 sets raw bit 7 for every received frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 raw, 1 enable, 2 coalescing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_rx_frame | input | 1 | One-cycle pulse per received frame |
| ev_tx_done | input | 1 | One-cycle pulse per transmitted packet |
| ev_tx_empty | input | 1 | One-cycle pulse when the transmit FIFO drains |
| irq | output | 1 | Level interrupt request |

## Verification
The gating path is driven by a table of enable words paired with transmit events. The table separates a mask that matches from one that does not, a closed port gate from a closed global gate, and all gates open with no event bit enabled. The coalescer is tried with frame bursts just short of the threshold and at the threshold, so a count that fails to restart or fires one frame late is caught. A single frame is then left to time out with a short timer, so the expiry cycle is placed within a narrow window. A frame consumed before a long timeout shows whether the coalescer fires on an empty queue. Same-cycle set and clear, on both a sticky bit and the pending-frame bit, shows which side wins.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int RAW_W        = 8;
    localparam int BIT_RX_ONE   = 0;
    localparam int BIT_TX_PKT   = 1;
    localparam int BIT_TX_EMPTY = 6;
    localparam int BIT_RX_MULTI = 7;
    localparam int GATE_PORT    = 18;
    localparam int GATE_GLOBAL  = 19;
    localparam int THR_LSB      = 24;
    localparam int THR_W        = 8;

    localparam logic [31:0] ENA_STORE_MASK = 32'h000C_00FF;

    localparam logic [1:0] WORD_RAW  = 2'd0;
    localparam logic [1:0] WORD_ENA  = 2'd1;
    localparam logic [1:0] WORD_COAL = 2'd2;

    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_COLLECT = 2'd1,
        CS_FIRE    = 2'd2
    } coal_state_t;
endpackage

// File: rtl/irqc_raw_status.sv
module irqc_raw_status
    import irqc_pkg::*;
#(
    parameter int PEND_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAW_W-1:0] set_vec,
    input  logic [RAW_W-1:0] clr_vec,
    output logic [RAW_W-1:0] raw_o
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    for (genvar i = 0; i < RAW_W; i++) begin : g_bit
        if (i == BIT_RX_ONE) begin : g_pending
            logic [PEND_W-1:0] pend_q;
            logic              inc;
            logic              dec;

            always_comb begin
                inc = set_vec[i] && (pend_q != PEND_MAX);
                dec = clr_vec[i] && (pend_q != '0);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q <= '0;
                end else begin
                    unique case ({inc, dec})
                        2'b10:   pend_q <= pend_q + 1'b1;
                        2'b01:   pend_q <= pend_q - 1'b1;
                        default: pend_q <= pend_q;
                    endcase
                end
            end

            assign raw_o[i] = (pend_q != '0);
        end else begin : g_sticky
            logic bit_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_vec[i]) begin
                    bit_q <= 1'b1;
                end else if (clr_vec[i]) begin
                    bit_q <= 1'b0;
                end
            end

            assign raw_o[i] = bit_q;
        end
    end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena_wr,
    input  logic [31:0]      ena_wdata,
    input  logic [RAW_W-1:0] raw_i,
    output logic [31:0]      ena_o,
    output logic             irq_o
);
    logic [31:0] ena_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (ena_wr) begin
            ena_q <= ena_wdata & ENA_STORE_MASK;
        end
    end

    always_comb begin
        logic any_src;
        any_src = |(raw_i & ena_q[RAW_W-1:0]);
        irq_o   = any_src && ena_q[GATE_PORT] && ena_q[GATE_GLOBAL];
        ena_o   = ena_q;
    end
endmodule

// File: rtl/irqc_rx_coalesce.sv
module irqc_rx_coalesce
    import irqc_pkg::*;
#(
    parameter int TMR_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_frame,
    input  logic             pending_nz,
    input  logic [THR_W-1:0] thr_i,
    input  logic [TMR_W-1:0] tmr_init_i,
    output logic             multi_evt_o,
    output coal_state_t      state_o
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    coal_state_t       state_q;
    coal_state_t       state_d;
    logic [THR_W-1:0]  cnt_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [PRE_W-1:0]  pre_q;
    logic [THR_W:0]    cnt_inc;
    logic [THR_W:0]    thr_eff;
    logic              tick;
    logic              expired;
    logic              load;
    logic              small_thr;

    always_comb begin
        cnt_inc   = {1'b0, cnt_q} + {{THR_W{1'b0}}, 1'b1};
        thr_eff   = (thr_i == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, thr_i};
        small_thr = (thr_i <= THR_W'(1));
        tick      = (pre_q == PRE_LAST);
        expired   = tick && (tmr_q == '0);
        load      = rx_frame && (state_q != CS_COLLECT);
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (rx_frame) state_d = small_thr ? CS_FIRE : CS_COLLECT;
            end
            CS_COLLECT: begin
                if (rx_frame && (cnt_inc >= thr_eff)) begin
                    state_d = CS_FIRE;
                end else if (expired) begin
                    state_d = (pending_nz || rx_frame) ? CS_FIRE : CS_IDLE;
                end
            end
            CS_FIRE: begin
                if (rx_frame) state_d = small_thr ? CS_FIRE : CS_COLLECT;
                else          state_d = CS_IDLE;
            end
            default: state_d = CS_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // frame count, countdown and prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmr_q <= '0;
            pre_q <= '0;
        end else begin
            if (state_d != CS_COLLECT)  cnt_q <= '0;
            else if (load)              cnt_q <= THR_W'(1);
            else if (rx_frame)          cnt_q <= cnt_inc[THR_W-1:0];

            if (load) begin
                tmr_q <= tmr_init_i;
                pre_q <= '0;
            end else if (state_q == CS_COLLECT) begin
                pre_q <= tick ? '0 : pre_q + 1'b1;
                if (tick && (tmr_q != '0)) tmr_q <= tmr_q - 1'b1;
            end else begin
                pre_q <= '0;
            end
        end
    end

    // output process
    always_comb begin
        multi_evt_o = (state_q == CS_FIRE);
        state_o     = state_q;
    end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int PEND_W       = 8,
    parameter int TMR_W        = 16,
    parameter int TICK_DIV     = 4,
    parameter int DEF_THR      = 8,
    parameter int DEF_TMR      = 'h74
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ev_rx_frame,
    input  logic        ev_tx_done,
    input  logic        ev_tx_empty,
    output logic        irq
);
    logic [RAW_W-1:0] raw_bits;
    logic [RAW_W-1:0] set_vec;
    logic [RAW_W-1:0] clr_vec;
    logic [31:0]      ena_bits;
    logic [THR_W-1:0] thr_q;
    logic [TMR_W-1:0] tmr_init_q;
    logic             multi_evt;
    logic             wr_raw;
    logic             wr_ena;
    logic             wr_coal;
    coal_state_t      coal_state;

    always_comb begin
        wr_raw  = reg_wr_en && (reg_addr == WORD_RAW);
        wr_ena  = reg_wr_en && (reg_addr == WORD_ENA);
        wr_coal = reg_wr_en && (reg_addr == WORD_COAL);
        clr_vec = wr_raw ? reg_wdata[RAW_W-1:0] : '0;
        set_vec = '0;
        set_vec[BIT_RX_ONE]   = ev_rx_frame;
        set_vec[BIT_TX_PKT]   = ev_tx_done;
        set_vec[BIT_TX_EMPTY] = ev_tx_empty;
        set_vec[BIT_RX_MULTI] = multi_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q      <= THR_W'(DEF_THR);
            tmr_init_q <= TMR_W'(DEF_TMR);
        end else if (wr_coal) begin
            thr_q      <= reg_wdata[THR_LSB +: THR_W];
            tmr_init_q <= reg_wdata[TMR_W-1:0];
        end
    end

    irqc_raw_status #(.PEND_W(PEND_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .raw_o   (raw_bits)
    );

    irqc_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ena_wr    (wr_ena),
        .ena_wdata (reg_wdata),
        .raw_i     (raw_bits),
        .ena_o     (ena_bits),
        .irq_o     (irq)
    );

    irqc_rx_coalesce #(.TMR_W(TMR_W), .TICK_DIV(TICK_DIV)) u_coal (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_frame    (ev_rx_frame),
        .pending_nz  (raw_bits[BIT_RX_ONE]),
        .thr_i       (thr_q),
        .tmr_init_i  (tmr_init_q),
        .multi_evt_o (multi_evt),
        .state_o     (coal_state)
    );

    always_comb begin
        unique case (reg_addr)
            WORD_RAW:  reg_rdata = 32'(raw_bits);
            WORD_ENA:  reg_rdata = ena_bits;
            WORD_COAL: reg_rdata = {thr_q, {(THR_LSB - TMR_W){1'b0}}, tmr_init_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk
    import irqc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        ev_rx_frame,
    input logic        ev_tx_done,
    input logic        ev_tx_empty,
    input logic        raw_rx_one,
    input logic        raw_tx_pkt,
    input logic        raw_tx_empty,
    input logic        raw_rx_multi,
    input logic        gate_port,
    input logic        gate_global,
    input logic        clr_tx_pkt,
    input logic        clr_tx_empty,
    input coal_state_t coal_state
);
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gate_port && gate_global));

    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_rx_one || raw_tx_pkt || raw_tx_empty || raw_rx_multi));

    p_tx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |=> raw_tx_pkt);

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_tx_done && !clr_tx_pkt) |=> $stable(raw_tx_pkt));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx_pkt && !ev_tx_done) |=> !raw_tx_pkt);

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_empty && clr_tx_empty) |=> raw_tx_empty);

    p_rx_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_frame |=> raw_rx_one);

    p_fire_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (coal_state == CS_FIRE) |=> raw_rx_multi);

    p_fire_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((coal_state == CS_FIRE) && !ev_rx_frame) |=> (coal_state == CS_IDLE));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .ev_rx_frame  (ev_rx_frame),
    .ev_tx_done   (ev_tx_done),
    .ev_tx_empty  (ev_tx_empty),
    .raw_rx_one   (raw_bits[0]),
    .raw_tx_pkt   (raw_bits[1]),
    .raw_tx_empty (raw_bits[6]),
    .raw_rx_multi (raw_bits[7]),
    .gate_port    (ena_bits[18]),
    .gate_global  (ena_bits[19]),
    .clr_tx_pkt   (clr_vec[1]),
    .clr_tx_empty (clr_vec[6]),
    .coal_state   (coal_state)
);

// File: tb/mac_irq_ctrl_bench.sv
module mac_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_rx_frame = 1'b0;
    logic        ev_tx_done = 1'b0;
    logic        ev_tx_empty = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_irq_ctrl u_mac_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ev_rx_frame (ev_rx_frame),
        .ev_tx_done  (ev_tx_done),
        .ev_tx_empty (ev_tx_empty),
        .irq         (irq)
    );

    // {enable word, {tx_done, tx_empty}, expected irq, expected raw}
    localparam logic [42:0] VEC [8] = '{
        {32'h000C_0002, 2'b10, 1'b1, 8'h02},
        {32'h000C_0002, 2'b01, 1'b0, 8'h40},
        {32'h000C_0040, 2'b01, 1'b1, 8'h40},
        {32'h0004_0002, 2'b10, 1'b0, 8'h02},
        {32'h0008_0002, 2'b10, 1'b0, 8'h02},
        {32'h000C_0000, 2'b11, 1'b0, 8'h42},
        {32'h0000_00FF, 2'b11, 1'b0, 8'h42},
        {32'h000C_00FF, 2'b11, 1'b1, 8'h42}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse(input logic td, input logic te, input logic rx);
        @(negedge clk);
        ev_tx_done  = td;
        ev_tx_empty = te;
        ev_rx_frame = rx;
        @(negedge clk);
        ev_tx_done  = 1'b0;
        ev_tx_empty = 1'b0;
        ev_rx_frame = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(3);
        // R1: reset state
        rd(2'd0, d); check("R1 raw", d, 32'h0);
        rd(2'd1, d); check("R1 ena", d, 32'h0);
        rd(2'd2, d); check("R1 coal", d, 32'h0800_0074);
        check("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R6: gating table
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 32'hFF);
            wr(2'd1, VEC[i][42:11]);
            pulse(VEC[i][10], VEC[i][9], 1'b0);
            check($sformatf("R6 irq vec%0d", i), 32'(irq), 32'(VEC[i][8]));
            rd(2'd0, d);
            check($sformatf("R2 raw vec%0d", i), d, 32'(VEC[i][7:0]));
        end

        // R5: stored enable bits only, unused words zero
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R5 ena mask", d, 32'h000C_00FF);
        rd(2'd3, d); check("R5 word3", d, 32'h0);
        wr(2'd0, 32'hFF);
        wr(2'd1, 32'h0);

        // R2: sticky and write-0 has no effect
        pulse(1'b1, 1'b0, 1'b0);
        wr(2'd0, 32'h00);
        idle(3);
        rd(2'd0, d); check("R2 write0 keeps", d, 32'h02);

        // R3: clear, and set beats clear in the same cycle
        wr(2'd0, 32'h02);
        rd(2'd0, d); check("R3 w1c", d, 32'h00);
        @(negedge clk);
        ev_tx_empty = 1'b1; reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h40;
        @(negedge clk);
        ev_tx_empty = 1'b0; reg_wr_en = 1'b0;
        rd(2'd0, d); check("R3 set wins", d, 32'h40);
        wr(2'd0, 32'hFF);

        // R7: threshold 3
        wr(2'd2, 32'h0300_0100);
        pulse(1'b0, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        idle(2);
        rd(2'd0, d); check("R7 below threshold", 32'(d[7]), 32'h0);
        pulse(1'b0, 1'b0, 1'b1);
        idle(2);
        rd(2'd0, d); check("R7 at threshold", 32'(d[7]), 32'h1);
        wr(2'd0, 32'h80);
        pulse(1'b0, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        idle(2);
        rd(2'd0, d); check("R7 count restarted", 32'(d[7]), 32'h0);
        pulse(1'b0, 1'b0, 1'b1);
        idle(2);
        rd(2'd0, d); check("R7 second burst", 32'(d[7]), 32'h1);
        wr(2'd0, 32'h80);

        // R4: six frames pending, one consumed per clear
        for (int k = 0; k < 5; k++) begin
            wr(2'd0, 32'h01);
            rd(2'd0, d); check($sformatf("R4 still pending %0d", k), 32'(d[0]), 32'h1);
        end
        wr(2'd0, 32'h01);
        rd(2'd0, d); check("R4 all consumed", 32'(d[0]), 32'h0);

        // R3 on the pending bit: frame and clear together keep it set
        pulse(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        ev_rx_frame = 1'b1; reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h01;
        @(negedge clk);
        ev_rx_frame = 1'b0; reg_wr_en = 1'b0;
        rd(2'd0, d); check("R3 pending set wins", 32'(d[0]), 32'h1);
        wr(2'd0, 32'h01);
        rd(2'd0, d); check("R3 pending cleared", 32'(d[0]), 32'h0);

        // R9: timer (0x100) expires with nothing pending
        idle(1200);
        rd(2'd0, d); check("R9 empty expiry", d, 32'h0);

        // R8: timer 3, threshold 8, one frame
        wr(2'd2, 32'h0800_0003);
        pulse(1'b0, 1'b0, 1'b1);
        idle((3 + 1) * TICK - 2);
        rd(2'd0, d); check("R8 before expiry", 32'(d[7]), 32'h0);
        idle(4);
        rd(2'd0, d); check("R8 after expiry", 32'(d[7]), 32'h1);
        wr(2'd0, 32'h81);

        // R10: thresholds 1 and 0
        wr(2'd2, 32'h0100_0100);
        pulse(1'b0, 1'b0, 1'b1);
        idle(2);
        rd(2'd0, d); check("R10 thr1", 32'(d[7]), 32'h1);
        wr(2'd0, 32'h81);
        wr(2'd2, 32'h0000_0100);
        pulse(1'b0, 1'b0, 1'b1);
        idle(2);
        rd(2'd0, d); check("R10 thr0", 32'(d[7]), 32'h1);
        wr(2'd0, 32'h81);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule